// File: doc/BRIEF.md
# Selectable-Sense Interrupt Request Latch

This block is the input stage of an interrupt controller. Each of its sources has a raw request line. The line passes through a two-flop synchronizer, and a sense mode then turns it into a one-bit pending flag. The four modes are level, falling edge, rising edge and both edges. A parameter mask chooses which sources come out of reset in level mode; every other source comes out of reset in rising-edge mode. Sources inside the external window have a writable mode entry. Sources outside the window keep their reset mode.

When a flag goes from clear to set, the block reports it to the downstream arbiter with a one-cycle notify pulse that carries the source number. The arbiter places one source in the outstanding slot with a grant and frees the slot with an acknowledge. An acknowledge clears the flag of an edge-sensed source. A level-sensed source keeps its flag for as long as its input stays high. If a level source in the slot drops its input, the block withdraws the request and frees the slot. Software can clear edge flags by writing zero. The notify output is a valid-only stream with no ready: each pulse lasts exactly one cycle, and the consumer must take it in that cycle because there is no back-pressure.

Top module: `isl_top`

## Requirements
- R1: A change on `irq_in` becomes visible in the flag, and in any notify it causes, on the third rising clock edge after the change.
- R2: In level mode (mode code 0) a flag is set while the synchronized input is high and cleared in the cycle after the input is seen low.
- R3: Falling-edge mode (code 1) sets the flag on a high-to-low change, rising-edge mode (code 2) on a low-to-high change, and both-edge mode (code 3) on any change. An edge flag stays set after the input settles.
- R4: The stored previous level of every source follows its input in every mode. A source held high in level mode and then switched to rising-edge mode therefore records no edge.
- R5: A write of 0x00 through `flag_we` clears the indexed flag only when that source is edge-sensed. A nonzero write, or any write to a level-sensed flag, leaves the flag unchanged. A trigger in the same cycle wins over a clear.
- R6: `flag_rdata` returns the indexed flag in bit 0, and bits 7:1 read as zero.
- R7: Mode entry k (`cfg_idx` = k) controls source EXT_BASE+k. With the default parameters the window is 32 entries long and covers sources 64 to 95. `cfg_rdata` returns the entry's mode in bits 3:2 and zero in every other bit.
- R8: After reset all flags, `notify_valid`, `busy` and `withdraw` are 0. Sources in LEVEL_MASK (by default 3, 64 and 65) are in level mode, and all other sources are in rising-edge mode.
- R9: `notify_valid` is high for exactly one cycle, the same cycle a flag first reads set. `notify_id` is the lowest source number among the flags set at that edge.
- R10: A grant while the slot is free records `grant_id` in `busy_id`, and a grant while the slot is busy is ignored. An `ack` frees the slot and clears the flag of an edge-sensed source; the flag of a level-sensed source stays set.
- R11: When the source in the slot is level-sensed and its synchronized input is low, `withdraw` pulses for one cycle. On that same edge the slot is freed and the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw request lines, asynchronous |
| cfg_we | input | 1 | Write strobe for a mode entry |
| cfg_idx | input | EXT_IW | Index of the mode entry to write or read |
| cfg_wmode | input | 2 | Sense mode code to write |
| cfg_rdata | output | 8 | Readback of the mode entry, mode in bits 3:2 |
| flag_we | input | 1 | Write strobe for a pending flag |
| flag_idx | input | SRC_IW | Index of the source to write or read |
| flag_wdata | input | 8 | Flag write data; only 0x00 clears |
| flag_rdata | output | 8 | Pending flag in bit 0 |
| grant_valid | input | 1 | Arbiter places a source in the outstanding slot |
| grant_id | input | SRC_IW | Source being granted |
| ack | input | 1 | Acknowledge of the outstanding source |
| notify_valid | output | 1 | One-cycle pulse when a flag becomes newly set |
| notify_id | output | SRC_IW | Source number carried by the notify pulse |
| busy | output | 1 | The outstanding slot is occupied |
| busy_id | output | SRC_IW | Source held in the outstanding slot |
| withdraw | output | 1 | One-cycle pulse when a level request is withdrawn |

## Verification
The hardest case to reach is withdrawal. It needs a level source whose flag is already pending, that source granted into the slot, and then its input dropping while it still holds the slot. The stimulus raises a level-default source and waits past the synchronizer. It then grants that source and releases its line, and samples exactly three edges later, when the withdraw pulse, the freed slot and the cleared flag must all appear together. The mode-switch case with no spurious edge is reached the same way: a windowed source is held high in level mode and then switched to rising-edge mode.

// File: rtl/isl_pkg.sv
package isl_pkg;
  localparam logic [1:0] SNS_LEVEL = 2'd0;
  localparam logic [1:0] SNS_FALL  = 2'd1;
  localparam logic [1:0] SNS_RISE  = 2'd2;
  localparam logic [1:0] SNS_BOTH  = 2'd3;
  localparam int MODE_LSB = 2;
endpackage

// File: rtl/isl_sync.sv
module isl_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/isl_mode_regs.sv
module isl_mode_regs import isl_pkg::*; #(
  parameter int                 NUM_SRC    = 96,
  parameter int                 EXT_BASE   = 64,
  parameter int                 EXT_CNT    = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int                EXT_IW     = (EXT_CNT > 1) ? $clog2(EXT_CNT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [EXT_IW-1:0]       cfg_idx,
  input  logic [1:0]              cfg_wmode,
  output logic [NUM_SRC-1:0][1:0] mode_o,
  output logic [7:0]              cfg_rdata
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [1:0] DEF = LEVEL_MASK[i] ? SNS_LEVEL : SNS_RISE;
    if (i >= EXT_BASE && i < EXT_BASE + EXT_CNT) begin : g_ext
      logic [1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= DEF;
        else if (cfg_we && cfg_idx == EXT_IW'(i - EXT_BASE)) r <= cfg_wmode;
      end
      assign mode_o[i] = r;
    end else begin : g_fix
      assign mode_o[i] = DEF;
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (int'(cfg_idx) < EXT_CNT)
      cfg_rdata[MODE_LSB +: 2] = mode_o[EXT_BASE + int'(cfg_idx)];
  end

  a_r7_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == '0) |=> (mode_o[EXT_BASE] == $past(cfg_wmode)));
endmodule

// File: rtl/isl_flag_cell.sv
module isl_flag_cell import isl_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s,
  input  logic [1:0] mode,
  input  logic       sw_clr,
  input  logic       ack_clr,
  output logic       flag,
  output logic       set_ev,
  output logic       lvl_low
);
  logic prev;
  logic issue;

  always_comb begin
    case (mode)
      SNS_LEVEL: issue = s;
      SNS_FALL:  issue = prev & ~s;
      SNS_RISE:  issue = ~prev & s;
      default:   issue = prev ^ s;
    endcase
  end

  assign set_ev  = issue & ~flag;
  assign lvl_low = (mode == SNS_LEVEL) & ~s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= s;
      if (issue)                    flag <= 1'b1;
      else if (mode == SNS_LEVEL)   flag <= 1'b0;
      else if (sw_clr || ack_clr)   flag <= 1'b0;
    end
  end

  a_r2_level_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_LEVEL && !s) |=> !flag);
  a_r5_edge_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SNS_LEVEL && sw_clr && !set_ev && !(mode == SNS_RISE && !prev && s)
     && !(mode == SNS_FALL && prev && !s) && !(mode == SNS_BOTH && prev != s)) |=> !flag);
endmodule

// File: rtl/isl_top.sv
module isl_top import isl_pkg::*; #(
  parameter int                 NUM_SRC    = 96,
  parameter int                 EXT_BASE   = 64,
  parameter int                 EXT_CNT    = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 96'h0000_0003_0000_0000_0000_0008,
  localparam int                SRC_IW     = $clog2(NUM_SRC),
  localparam int                EXT_IW     = (EXT_CNT > 1) ? $clog2(EXT_CNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [EXT_IW-1:0]  cfg_idx,
  input  logic [1:0]         cfg_wmode,
  output logic [7:0]         cfg_rdata,
  input  logic               flag_we,
  input  logic [SRC_IW-1:0]  flag_idx,
  input  logic [7:0]         flag_wdata,
  output logic [7:0]         flag_rdata,
  input  logic               grant_valid,
  input  logic [SRC_IW-1:0]  grant_id,
  input  logic               ack,
  output logic               notify_valid,
  output logic [SRC_IW-1:0]  notify_id,
  output logic               busy,
  output logic [SRC_IW-1:0]  busy_id,
  output logic               withdraw
);
  logic [NUM_SRC-1:0]      s_irq;
  logic [NUM_SRC-1:0][1:0] mode;
  logic [NUM_SRC-1:0]      flags, set_ev, lvl_low, sw_clr, ack_clr;
  logic                    any_set;
  logic [SRC_IW-1:0]       first_set;
  logic                    wd_hit;

  isl_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(s_irq));

  isl_mode_regs #(.NUM_SRC(NUM_SRC), .EXT_BASE(EXT_BASE), .EXT_CNT(EXT_CNT),
                  .LEVEL_MASK(LEVEL_MASK)) u_modes (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wmode(cfg_wmode), .mode_o(mode), .cfg_rdata(cfg_rdata));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    assign sw_clr[i]  = flag_we && (flag_idx == SRC_IW'(i)) && (flag_wdata == 8'h00);
    assign ack_clr[i] = ack && busy && (busy_id == SRC_IW'(i));
    isl_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .s(s_irq[i]), .mode(mode[i]),
      .sw_clr(sw_clr[i]), .ack_clr(ack_clr[i]),
      .flag(flags[i]), .set_ev(set_ev[i]), .lvl_low(lvl_low[i]));
  end

  always_comb begin
    first_set = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (set_ev[i]) first_set = SRC_IW'(i);
  end
  assign any_set = |set_ev;

  always_comb begin
    flag_rdata = 8'h00;
    if (int'(flag_idx) < NUM_SRC) flag_rdata[0] = flags[flag_idx];
  end

  assign wd_hit = busy && lvl_low[busy_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify_valid <= 1'b0;
      notify_id    <= '0;
      busy         <= 1'b0;
      busy_id      <= '0;
      withdraw     <= 1'b0;
    end else begin
      notify_valid <= any_set;
      notify_id    <= first_set;
      withdraw     <= wd_hit;
      if (ack || wd_hit) begin
        busy <= 1'b0;
      end else if (grant_valid && !busy && int'(grant_id) < NUM_SRC) begin
        busy    <= 1'b1;
        busy_id <= grant_id;
      end
    end
  end

  a_r9_notify_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> flags[notify_id]);
  a_r11_withdraw_frees: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw |-> !busy);
  a_r10_busy_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(busy_id)));
  a_r11_withdraw_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw |-> !flags[$past(busy_id)]);
endmodule

// File: tb/sim_isl_top.sv
`timescale 1ns/1ps
module sim_isl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [1:0]  cfg_wmode = '0;
  logic [7:0]  cfg_rdata;
  logic        flag_we = 1'b0;
  logic [6:0]  flag_idx = '0;
  logic [7:0]  flag_wdata = '0;
  logic [7:0]  flag_rdata;
  logic        grant_valid = 1'b0;
  logic [6:0]  grant_id = '0;
  logic        ack = 1'b0;
  logic        notify_valid;
  logic [6:0]  notify_id;
  logic        busy;
  logic [6:0]  busy_id;
  logic        withdraw;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  isl_top u0 (.*);

  // entry: {mode[1:0], start level, end level, expected flag}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_0, 5'b00_01_1, 5'b00_10_0, 5'b00_11_1,
    5'b01_00_0, 5'b01_01_0, 5'b01_10_1, 5'b01_11_0,
    5'b10_00_0, 5'b10_01_1, 5'b10_10_0, 5'b10_11_0,
    5'b11_00_0, 5'b11_01_1, 5'b11_10_1, 5'b11_11_0};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_flag(input int idx, output logic [7:0] v);
    flag_idx = 7'(idx);
    #0.5;
    v = flag_rdata;
  endtask

  task automatic wr_flag(input int idx, input logic [7:0] v);
    flag_idx = 7'(idx); flag_wdata = v; flag_we = 1'b1;
    tick(1);
    flag_we = 1'b0;
  endtask

  task automatic wr_cfg(input int idx, input logic [1:0] m);
    cfg_idx = 5'(idx); cfg_wmode = m; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic do_grant(input int id);
    grant_id = 7'(id); grant_valid = 1'b1;
    tick(1);
    grant_valid = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    // R8 reset state
    chk("R8 notify", notify_valid, 0);
    chk("R8 busy", busy, 0);
    chk("R8 withdraw", withdraw, 0);
    rd_flag(10, v); chk("R8 flag", v, 0);
    cfg_idx = 5'd0; #0.5; chk("R8 src64 level", cfg_rdata, 8'h00);
    cfg_idx = 5'd2; #0.5; chk("R8 src66 rise", cfg_rdata, 8'h08);
    rst_n = 1'b1;
    tick(1);

    // R1 latency on rising-edge source 10
    irq_in[10] = 1'b1;
    tick(2);
    rd_flag(10, v); chk("R1 not yet", v, 0);
    chk("R1 no notify yet", notify_valid, 0);
    tick(1);
    rd_flag(10, v); chk("R1 flag", v, 8'h01);
    chk("R9 notify", notify_valid, 1);
    chk("R9 notify id", notify_id, 10);
    tick(1);
    chk("R9 one cycle", notify_valid, 0);
    irq_in[10] = 1'b0;
    tick(4);
    rd_flag(10, v); chk("R3 edge flag persists", v, 8'h01);
    chk("R6 full byte", v, 8'h01);

    // R9 lowest index among simultaneous sets
    irq_in[20] = 1'b1; irq_in[12] = 1'b1;
    tick(3);
    chk("R9 both notify", notify_valid, 1);
    chk("R9 lowest id", notify_id, 12);
    tick(1);
    rd_flag(20, v); chk("R3 src20", v, 8'h01);

    // R10 slot handling
    do_grant(12);
    chk("R10 busy", busy, 1);
    chk("R10 id", busy_id, 12);
    do_grant(20);
    chk("R10 ignored grant", busy_id, 12);
    do_ack();
    chk("R10 freed", busy, 0);
    rd_flag(12, v); chk("R10 edge flag cleared", v, 0);
    rd_flag(20, v); chk("R10 other flag kept", v, 8'h01);

    // R5 software writes
    wr_flag(20, 8'h02);
    rd_flag(20, v); chk("R5 nonzero ignored", v, 8'h01);
    wr_flag(20, 8'h00);
    rd_flag(20, v); chk("R5 edge cleared", v, 0);

    // level source 3
    irq_in[3] = 1'b1;
    tick(4);
    rd_flag(3, v); chk("R2 level set", v, 8'h01);
    wr_flag(3, 8'h00);
    rd_flag(3, v); chk("R5 level write ignored", v, 8'h01);
    do_grant(3);
    do_ack();
    chk("R10 level ack frees", busy, 0);
    rd_flag(3, v); chk("R10 level flag kept", v, 8'h01);

    // R11 withdrawal
    do_grant(3);
    chk("R11 granted", busy, 1);
    irq_in[3] = 1'b0;
    tick(2);
    chk("R11 early", withdraw, 0);
    chk("R11 still busy", busy, 1);
    tick(1);
    chk("R11 withdraw", withdraw, 1);
    chk("R11 slot free", busy, 0);
    rd_flag(3, v); chk("R11 flag clear", v, 0);
    tick(1);
    chk("R11 pulse one cycle", withdraw, 0);

    // R7 window readback
    wr_cfg(5, 2'd3);
    cfg_idx = 5'd5; #0.5; chk("R7 readback", cfg_rdata, 8'h0C);

    // R4 previous level tracked through a mode switch on source 70
    wr_cfg(6, 2'd0);
    irq_in[70] = 1'b1;
    tick(4);
    rd_flag(70, v); chk("R2 src70 level", v, 8'h01);
    wr_cfg(6, 2'd2);
    wr_flag(70, 8'h00);
    rd_flag(70, v); chk("R5 cleared after switch", v, 0);
    tick(4);
    rd_flag(70, v); chk("R4 no spurious edge", v, 0);

    // mode table on source 70 through window entry 6
    for (int k = 0; k < 16; k++) begin
      wr_cfg(6, VEC[k][4:3]);
      irq_in[70] = VEC[k][2];
      tick(4);
      wr_flag(70, 8'h00);
      irq_in[70] = VEC[k][1];
      tick(4);
      rd_flag(70, v);
      chk($sformatf("R3 R2 R7 vector %0d", k), v, {7'b0, VEC[k][0]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule